// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block drives the board-level reset line when a watchdog expires. A single 32-bit configuration register holds a 20-bit pulse length, an output polarity bit and a drive-mode bit. The length field takes whatever each write carries. The polarity and drive-mode bits change only when the top byte of the write is one of four key values. Any other top byte leaves them as they are. This stops a stray or careless write from flipping the sense of a reset line.

When the trigger input is seen while the block is idle, the reset line is asserted for the programmed number of 1 µs ticks plus one. The ticks come from a one-cycle enable pulse at 1 MHz. An output-enable pin lets the pad model open-drain drive: in that mode the line is driven only while asserted and released otherwise. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. A register write is a single-cycle strobe. The trigger is a level sampled on each clock.

Top module: `ext_rst_pulse`

## Requirements
- R1: After reset the length field is 0xFF, the polarity is active-low, the drive mode is open-drain, the register reads 0x000000FF, `busy` is 0, `rst_line` is 1 and `rst_line_oe` is 0.
- R2: Every write stores bits 19:0 of the write data as the pulse length, whatever the top byte holds.
- R3: A write whose bits 31:24 equal 0xA5 makes the output active-high. A write whose top byte equals 0x5A makes it active-low.
- R4: A write whose bits 31:24 equal 0xA8 selects push-pull drive. A write whose top byte equals 0x8A selects open-drain drive.
- R5: A write with any other top-byte value leaves polarity and drive mode unchanged.
- R6: The read value has bit 31 = 1 when active-high, bit 30 = 1 when push-pull, bits 29:20 zero, and bits 19:0 equal to the length field.
- R7: A trigger seen at a clock edge while idle sets `busy` from that edge. `busy` stays set through exactly N+1 tick pulses, where N is the length field at the trigger, and clears at the edge of the last of those ticks.
- R8: A trigger that arrives while `busy` is set is ignored and does not lengthen the pulse.
- R9: While `busy` is set, `rst_line` equals the polarity bit. While idle, it equals the inverse of the polarity bit.
- R10: In push-pull mode `rst_line_oe` is always 1. In open-drain mode it is 1 only while `busy` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle enable at 1 MHz |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read value |
| trigger | input | 1 | Watchdog expiry; starts a pulse when idle |
| busy | output | 1 | High while the pulse is in progress |
| rst_line | output | 1 | Reset line level |
| rst_line_oe | output | 1 | Output enable for the reset line pad |

## Verification
A register write is visible on `cfg_rdata` at the edge that takes the strobe. The bench drives one cycle after an edge and reads back at the next falling edge. A trigger sets `busy` and the asserted level at the edge that samples it, so the levels are checked one and two cycles later. The pulse length is measured as the number of tick pulses seen on falling edges while `busy` is high. A scoreboard queue holds the expected N+1 for each accepted trigger and compares it when `busy` falls, which also catches a pulse that a second trigger has lengthened.

// File: rtl/ext_rst_pulse_pkg.sv
package ext_rst_pulse_pkg;
  localparam int REG_W   = 32;
  localparam int KEY_W   = 8;
  localparam logic [KEY_W-1:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [KEY_W-1:0] KEY_DRV_OD   = 8'h8A;
endpackage

// File: rtl/ext_rst_pulse_cfg.sv
module ext_rst_pulse_cfg
  import ext_rst_pulse_pkg::*;
#(
  parameter int LEN_W   = 20,
  parameter int LEN_RST = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [LEN_W-1:0] len,
  output logic             pol_high,
  output logic             push_pull
);
  localparam int PAD_W = REG_W - 2 - LEN_W;

  logic [KEY_W-1:0] key;
  logic [LEN_W-1:0] len_q;
  logic             pol_q, pp_q;

  assign key = wdata[REG_W-1 -: KEY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(LEN_RST);
      pol_q <= 1'b0;
      pp_q  <= 1'b0;
    end else if (we) begin
      len_q <= wdata[LEN_W-1:0];
      if (key == KEY_POL_HIGH) pol_q <= 1'b1;
      else if (key == KEY_POL_LOW) pol_q <= 1'b0;
      if (key == KEY_DRV_PP) pp_q <= 1'b1;
      else if (key == KEY_DRV_OD) pp_q <= 1'b0;
    end
  end

  assign len       = len_q;
  assign pol_high  = pol_q;
  assign push_pull = pp_q;
  assign rdata     = {pol_q, pp_q, {PAD_W{1'b0}}, len_q};

  // R2
  len_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> len_q == $past(wdata[LEN_W-1:0]));
  // R5
  pol_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (key == KEY_POL_HIGH || key == KEY_POL_LOW)) |=> $stable(pol_q));
  // R5
  drv_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (key == KEY_DRV_PP || key == KEY_DRV_OD)) |=> $stable(pp_q));
endmodule

// File: rtl/ext_rst_pulse_timer.sv
module ext_rst_pulse_timer #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q;
  logic             active_q;
  logic             last_tick;

  assign last_tick = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (fire) begin
        active_q <= 1'b1;
        cnt_q    <= len;
      end
    end else if (tick) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active = active_q;

  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && fire |=> active_q && cnt_q == $past(len));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !last_tick |=> active_q);
  // R7
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && last_tick |=> !active_q);
  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ext_rst_pulse_pad.sv
module ext_rst_pulse_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pol_high,
  input  logic push_pull,
  output logic line,
  output logic line_oe
);
  always_comb begin
    line    = active ? pol_high : !pol_high;
    line_oe = push_pull || active;
  end

  // R10
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull && !active |-> !line_oe);
  // R10
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |-> line_oe);
  // R9
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> line == pol_high);
endmodule

// File: rtl/ext_rst_pulse.sv
module ext_rst_pulse
  import ext_rst_pulse_pkg::*;
#(
  parameter int LEN_W   = 20,
  parameter int LEN_RST = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             trigger,
  output logic             busy,
  output logic             rst_line,
  output logic             rst_line_oe
);
  logic [LEN_W-1:0] len;
  logic             pol_high, push_pull, active;

  ext_rst_pulse_cfg #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .len(len), .pol_high(pol_high), .push_pull(push_pull)
  );

  ext_rst_pulse_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .fire(trigger),
    .len(len), .active(active)
  );

  ext_rst_pulse_pad u_pad (
    .clk(clk), .rst_n(rst_n), .active(active), .pol_high(pol_high),
    .push_pull(push_pull), .line(rst_line), .line_oe(rst_line_oe)
  );

  assign busy = active;
endmodule

// File: tb/ext_rst_pulse_bench.sv
module ext_rst_pulse_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        us_tick = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        trigger = 0;
  logic        busy, rst_line, rst_line_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_q[$];
  int tick_cnt = 0;
  bit busy_prev = 0;

  always #2 clk = ~clk;

  ext_rst_pulse u_ext_rst_pulse (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trigger(trigger),
    .busy(busy), .rst_line(rst_line), .rst_line_oe(rst_line_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // tick generator: one cycle high in five
  initial begin
    forever begin
      for (int i = 0; i < 5; i++) begin
        @(posedge clk); #1;
        us_tick = (i == 4);
      end
    end
  end

  // monitor: counts ticks while busy, compares on busy fall
  always @(negedge clk) begin
    if (busy && us_tick) tick_cnt++;
    if (busy_prev && !busy) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R8: actual %0d ticks expected no pulse", tick_cnt);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (tick_cnt != e) begin
          errors++;
          $display("FAIL R7/R8: actual %0d ticks expected %0d", tick_cnt, e);
        end
      end
      tick_cnt = 0;
    end
    busy_prev = busy;
  end

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic fire(input int exp_ticks);
    @(posedge clk); #1;
    trigger = 1;
    exp_q.push_back(exp_ticks);
    @(posedge clk); #1;
    trigger = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 rdata", cfg_rdata, 32'h0000_00FF);
    check("R1 busy", busy, 0);
    check("R1 line", rst_line, 1);
    check("R1 oe", rst_line_oe, 0);

    // R7 default length: 256 ticks; R9/R10 open-drain active-low during pulse
    fire(256);
    @(negedge clk);
    check("R9 od low level", rst_line, 0);
    check("R10 od oe asserted", rst_line_oe, 1);
    check("R7 busy", busy, 1);
    wait_idle();
    check("R10 od released", rst_line_oe, 0);

    // R3/R2/R6 active-high key with length 3
    wr(32'hA500_0003);
    check("R3 R6 active-high", cfg_rdata, 32'h8000_0003);
    // R4 push-pull key
    wr(32'hA800_0005);
    check("R4 push-pull", cfg_rdata, 32'hC000_0005);
    // R5 non-key top byte keeps mode, stores length
    wr(32'h1200_0007);
    check("R5 R2 no key", cfg_rdata, 32'hC000_0007);
    // R6 bits 29:20 read zero
    wr(32'h3FF0_0009);
    check("R6 pad zero", cfg_rdata, 32'hC000_0009);
    check("R10 pp idle oe", rst_line_oe, 1);
    check("R9 idle active-high", rst_line, 0);

    // R7 length 3 -> 4 ticks, R8 retrigger ignored
    wr(32'h0000_0003);
    fire(4);
    @(negedge clk);
    check("R9 high level", rst_line, 1);
    check("R10 pp oe", rst_line_oe, 1);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 trigger = 1;
    @(posedge clk); #1 trigger = 0;
    wait_idle();
    check("R8 queue empty", exp_q.size(), 0);

    // R7 length 0 -> one tick
    wr(32'h0000_0000);
    fire(1);
    wait_idle();

    // R3/R4 back to active-low open-drain
    wr(32'h5A00_0002);
    check("R3 active-low", cfg_rdata, 32'h4000_0002);
    wr(32'h8A00_0002);
    check("R4 open-drain", cfg_rdata, 32'h0000_0002);
    check("R10 od idle", rst_line_oe, 0);
    fire(3);
    @(negedge clk);
    check("R9 low level", rst_line, 0);
    wait_idle();
    check("R9 idle high", rst_line, 1);

    // R2 maximum length readback
    wr(32'h000F_FFFF);
    check("R2 max len", cfg_rdata, 32'h000F_FFFF);
    check("R7 all pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule